// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block is the protocol and sequencing core of a serial flash device. It acts as a slave on a four-wire SPI link, in either idle-low or idle-high clock mode. Each transaction starts with a one-byte opcode. Depending on the opcode, address bytes, dummy bytes or data bytes follow, and response data is shifted back most significant bit first. Every SPI pin is sampled by the system clock through a short synchronizer, so the serial clock must run several times slower than the system clock.

Write-type commands are held until chip select rises. They take effect only if the transaction ended on a byte boundary. Program, erase and status-write commands then start a self-timed busy cycle. Its length is a parameter in system-clock ticks, and during that cycle a walker updates a behavioural byte array. While the cycle runs, only the status read is served. A deep power-down state ignores every opcode except the release command.

The array is modelled with a parameterised address width. Address bits above that width are ignored, so reads wrap at the top of the modelled memory.

Top module: `spi_flash_seq`

## Requirements
- R1: After reset the status byte reads 00h, the serial output enable is low, and every array byte reads FFh.
- R2: Opcode 9Fh returns the bytes 7Fh, 37h, 02h, 13h in that order. Input bits are taken on serial-clock rising edges and output bits change after falling edges, MSB first, with the clock idling either low or high.
- R3: Opcode 06h sets the write-enable flag and opcode 04h clears it. The status byte holds the busy flag in bit 0, the write-enable flag in bit 1, the stored bits 7 and 4..2, and zeros in bits 6..5.
- R4: Opcodes 01h, 02h, D8h and C7h have no effect unless the write-enable flag is set.
- R5: Opcodes 06h, 04h, 01h, 02h, D8h, C7h and B9h are discarded unless chip select rises after a whole number of 8-bit groups.
- R6: Page program (02h, 3 address bytes, then data) only clears bits (new = old AND data). Busy (status bit 0) is set from the rise of chip select until the cycle ends, and the write-enable flag is cleared.
- R7: Program data that runs past the end of a 256-byte page continues at the start of the same page.
- R8: When more than 256 data bytes arrive in one page program, only the last 256 are written.
- R9: Read (03h, 3 address bytes) and fast read (0Bh, 3 address bytes plus one dummy byte) stream bytes from successive addresses. The address wraps to zero past the top, and address bits above the array width are ignored.
- R10: While busy, every opcode except 05h is ignored: no output, no flag change, no array change.
- R11: Opcode D8h sets every byte of the 512-byte sector holding the address to FFh. Opcode C7h sets the whole array to FFh.
- R12: Opcode 01h with one data byte stores its bits 7 and 4..2 into the status byte, runs a busy cycle and clears the write-enable flag.
- R13: Opcode B9h enters deep power-down, in which every opcode except ABh is ignored. ABh takes three dummy bytes, then repeats 13h, and leaves deep power-down when chip select rises.
- R14: The serial output enable is high only while selected in a data-out phase. Otherwise the serial output is high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the bus master |
| csn | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out, high impedance when not driving |
| miso_oe | output | 1 | High while the serial output is driven |

## Verification
The checker assumes that every serial-clock level and chip-select level lasts several system clocks, so the synchronizer never misses an edge. It also assumes that chip select stays high long enough for the commit to be registered before the next selection. The bench keeps each half serial period at eight system clocks and holds chip select high for four half periods between transactions. It also polls the busy flag before every new write-type command, except where it deliberately probes the busy window.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_FAST = 8'h0B;
    localparam logic [7:0] OP_PP   = 8'h02;
    localparam logic [7:0] OP_SE   = 8'hD8;
    localparam logic [7:0] OP_BE   = 8'hC7;
    localparam logic [7:0] OP_DP   = 8'hB9;
    localparam logic [7:0] OP_RDID = 8'h9F;
    localparam logic [7:0] OP_RES  = 8'hAB;

    localparam logic [7:0] SIGNATURE = 8'h13;

    typedef enum logic [2:0] {
        PH_CMD, PH_ADDR, PH_DUMMY, PH_IN, PH_OUT, PH_TAIL, PH_IGN
    } phase_e;

    typedef enum logic [3:0] {
        K_NONE, K_WREN, K_WRDI, K_WRSR, K_PP, K_SE, K_BE, K_DP, K_RES
    } kind_e;

    typedef enum logic [1:0] {
        W_NONE, W_PROG, W_ERASE
    } wop_e;

    typedef struct packed {
        kind_e       kind;
        logic [23:0] addr;
        logic [7:0]  sr;
    } commit_t;

    function automatic logic [7:0] id_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    return 8'h7F;
            2'd1:    return 8'h37;
            2'd2:    return 8'h02;
            default: return 8'h13;
        endcase
    endfunction

endpackage

// File: rtl/spi_flash_sync.sv
module spi_flash_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) chain[k] <= RST_VAL;
            q_prev <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
            q_prev <= chain[STAGES-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_flash_array.sv
module spi_flash_array #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [7:0]        rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [7:0]        rdata_b
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= 8'hFF;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/spi_flash_cmd.sv
module spi_flash_cmd
    import spi_flash_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              cs_rise,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi_s,
    input  logic              busy,
    input  logic              dpd,
    input  logic [7:0]        status,
    input  logic [7:0]        arr_rdata,
    output logic [ADDR_W-1:0] arr_raddr,
    output logic              pb_clr,
    output logic              pb_we,
    output logic [PAGE_W-1:0] pb_idx,
    output logic [7:0]        pb_data,
    output logic              commit_vld,
    output commit_t           commit,
    output logic              miso_bit,
    output logic              miso_oe
);

    phase_e            phase;
    logic [2:0]        bc;
    logic [6:0]        rx;
    logic [7:0]        op;
    logic [23:0]       addr;
    logic [1:0]        acnt;
    logic [1:0]        dcnt;
    logic              got;
    logic [PAGE_W-1:0] pidx;
    logic [7:0]        sr_data;
    logic [2:0]        ob;
    logic [7:0]        tx;
    logic [1:0]        idx;

    logic [7:0]  byte_n;
    logic [23:0] addr_n;
    logic [7:0]  src;
    kind_e       nk;

    assign byte_n    = {rx, mosi_s};
    assign addr_n    = {addr[15:0], byte_n};
    assign arr_raddr = addr[ADDR_W-1:0];
    assign miso_oe   = sel && (phase == PH_OUT);

    always_comb begin
        case (op)
            OP_RDSR:         src = status;
            OP_READ, OP_FAST: src = arr_rdata;
            OP_RDID:         src = id_byte(idx);
            default:         src = SIGNATURE;
        endcase
    end

    always_comb begin
        nk = K_NONE;
        if (bc == 3'd0) begin
            if (phase == PH_TAIL) begin
                case (op)
                    OP_WREN: nk = K_WREN;
                    OP_WRDI: nk = K_WRDI;
                    OP_BE:   nk = K_BE;
                    OP_DP:   nk = K_DP;
                    OP_SE:   nk = K_SE;
                    default: nk = K_NONE;
                endcase
            end else if (phase == PH_IN && got) begin
                if (op == OP_WRSR)    nk = K_WRSR;
                else if (op == OP_PP) nk = K_PP;
            end
        end
        if (op == OP_RES && (phase == PH_DUMMY || phase == PH_OUT)) nk = K_RES;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_CMD;
            bc         <= '0;
            rx         <= '0;
            op         <= '0;
            addr       <= '0;
            acnt       <= '0;
            dcnt       <= '0;
            got        <= 1'b0;
            pidx       <= '0;
            sr_data    <= '0;
            ob         <= '0;
            tx         <= '0;
            idx        <= '0;
            pb_clr     <= 1'b0;
            pb_we      <= 1'b0;
            pb_idx     <= '0;
            pb_data    <= '0;
            commit_vld <= 1'b0;
            commit     <= '0;
            miso_bit   <= 1'b0;
        end else begin
            pb_clr     <= 1'b0;
            pb_we      <= 1'b0;
            commit_vld <= 1'b0;
            if (!sel) begin
                if (cs_rise && nk != K_NONE) begin
                    commit_vld  <= 1'b1;
                    commit.kind <= nk;
                    commit.addr <= addr;
                    commit.sr   <= sr_data;
                end
                phase <= PH_CMD;
                bc    <= '0;
                acnt  <= '0;
                got   <= 1'b0;
                ob    <= '0;
                idx   <= '0;
            end else begin
                if (sck_rise) begin
                    rx <= byte_n[6:0];
                    bc <= bc + 3'd1;
                    if (bc == 3'd7) begin
                        case (phase)
                            PH_CMD: begin
                                op <= byte_n;
                                if ((dpd && byte_n != OP_RES) || (busy && byte_n != OP_RDSR)) begin
                                    phase <= PH_IGN;
                                end else begin
                                    case (byte_n)
                                        OP_WREN, OP_WRDI, OP_BE, OP_DP: phase <= PH_TAIL;
                                        OP_RDSR, OP_RDID:               phase <= PH_OUT;
                                        OP_WRSR:                        phase <= PH_IN;
                                        OP_READ, OP_FAST, OP_SE:        phase <= PH_ADDR;
                                        OP_PP: begin
                                            phase  <= PH_ADDR;
                                            pb_clr <= 1'b1;
                                        end
                                        OP_RES: begin
                                            phase <= PH_DUMMY;
                                            dcnt  <= 2'd2;
                                        end
                                        default: phase <= PH_IGN;
                                    endcase
                                end
                            end
                            PH_ADDR: begin
                                addr <= addr_n;
                                acnt <= acnt + 2'd1;
                                if (acnt == 2'd2) begin
                                    case (op)
                                        OP_READ: phase <= PH_OUT;
                                        OP_FAST: begin
                                            phase <= PH_DUMMY;
                                            dcnt  <= 2'd0;
                                        end
                                        OP_PP: begin
                                            phase <= PH_IN;
                                            pidx  <= addr_n[PAGE_W-1:0];
                                        end
                                        default: phase <= PH_TAIL;
                                    endcase
                                end
                            end
                            PH_DUMMY: begin
                                if (dcnt == 2'd0) phase <= PH_OUT;
                                else              dcnt  <= dcnt - 2'd1;
                            end
                            PH_IN: begin
                                got <= 1'b1;
                                if (op == OP_PP) begin
                                    pb_we   <= 1'b1;
                                    pb_idx  <= pidx;
                                    pb_data <= byte_n;
                                    pidx    <= pidx + 1'b1;
                                end else if (!got) begin
                                    sr_data <= byte_n;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                if (sck_fall && phase == PH_OUT) begin
                    ob <= ob + 3'd1;
                    if (ob == 3'd0) begin
                        miso_bit <= src[7];
                        tx       <= {src[6:0], 1'b0};
                        if (op == OP_READ || op == OP_FAST) addr <= addr + 24'd1;
                        if (op == OP_RDID) idx <= idx + 2'd1;
                    end else begin
                        miso_bit <= tx[7];
                        tx       <= {tx[6:0], 1'b0};
                    end
                end
            end
        end
    end

endmodule

// File: rtl/spi_flash_exec.sv
module spi_flash_exec
    import spi_flash_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 8,
    parameter int SECT_W = 9,
    parameter int T_PP   = 400,
    parameter int T_SE   = 800,
    parameter int T_BE   = 1500,
    parameter int T_WRSR = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_vld,
    input  commit_t           commit,
    input  logic              pb_clr,
    input  logic              pb_we,
    input  logic [PAGE_W-1:0] pb_idx,
    input  logic [7:0]        pb_data,
    output logic              busy,
    output logic              wel,
    output logic              dpd,
    output logic [7:0]        status,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_waddr,
    output logic [7:0]        arr_wdata,
    output logic [ADDR_W-1:0] arr_qaddr,
    input  logic [7:0]        arr_qdata
);

    localparam int MEM  = 1 << ADDR_W;
    localparam int PAGE = 1 << PAGE_W;
    localparam int SECT = 1 << SECT_W;
    localparam int LW   = ADDR_W + 1;

    logic [7:0]        pbuf [PAGE];
    logic [PAGE-1:0]   pval;
    logic              srwd;
    logic [2:0]        bp;
    wop_e              wop;
    logic [ADDR_W-1:0] wbase;
    logic [LW-1:0]     wlen;
    logic [LW-1:0]     widx;
    logic [31:0]       timer;
    logic [31:0]       tgoal;
    logic              walking;
    logic [PAGE_W-1:0] slot;

    assign status    = {srwd, 2'b00, bp, wel, busy};
    assign walking   = busy && (widx < wlen);
    assign slot      = widx[PAGE_W-1:0];
    assign arr_qaddr = wbase + widx[ADDR_W-1:0];
    assign arr_waddr = arr_qaddr;
    assign arr_we    = walking && ((wop == W_ERASE) || (wop == W_PROG && pval[slot]));
    assign arr_wdata = (wop == W_ERASE) ? 8'hFF : (arr_qdata & pbuf[slot]);

    always_ff @(posedge clk) begin
        if (pb_we) pbuf[pb_idx] <= pb_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pval  <= '0;
            busy  <= 1'b0;
            wel   <= 1'b0;
            dpd   <= 1'b0;
            srwd  <= 1'b0;
            bp    <= '0;
            wop   <= W_NONE;
            wbase <= '0;
            wlen  <= '0;
            widx  <= '0;
            timer <= '0;
            tgoal <= '0;
        end else begin
            if (pb_clr)     pval         <= '0;
            else if (pb_we) pval[pb_idx] <= 1'b1;

            if (busy) begin
                timer <= timer + 32'd1;
                if (walking)               widx <= widx + 1'b1;
                else if (timer >= tgoal)   busy <= 1'b0;
            end else if (commit_vld) begin
                widx  <= '0;
                timer <= '0;
                case (commit.kind)
                    K_WREN: wel <= 1'b1;
                    K_WRDI: wel <= 1'b0;
                    K_DP:   dpd <= 1'b1;
                    K_RES:  dpd <= 1'b0;
                    K_WRSR: if (wel) begin
                        wel   <= 1'b0;
                        busy  <= 1'b1;
                        srwd  <= commit.sr[7];
                        bp    <= commit.sr[4:2];
                        wop   <= W_NONE;
                        wlen  <= '0;
                        tgoal <= 32'(T_WRSR);
                    end
                    K_PP: if (wel) begin
                        wel   <= 1'b0;
                        busy  <= 1'b1;
                        wop   <= W_PROG;
                        wbase <= {commit.addr[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
                        wlen  <= LW'(PAGE);
                        tgoal <= 32'(T_PP);
                    end
                    K_SE: if (wel) begin
                        wel   <= 1'b0;
                        busy  <= 1'b1;
                        wop   <= W_ERASE;
                        wbase <= {commit.addr[ADDR_W-1:SECT_W], {SECT_W{1'b0}}};
                        wlen  <= LW'(SECT);
                        tgoal <= 32'(T_SE);
                    end
                    K_BE: if (wel) begin
                        wel   <= 1'b0;
                        busy  <= 1'b1;
                        wop   <= W_ERASE;
                        wbase <= '0;
                        wlen  <= LW'(MEM);
                        tgoal <= 32'(T_BE);
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
    import spi_flash_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int PAGE_W  = 8,
    parameter int SECT_W  = 9,
    parameter int SYNC_ST = 2,
    parameter int T_PP    = 400,
    parameter int T_SE    = 800,
    parameter int T_BE    = 1500,
    parameter int T_WRSR  = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic csn,
    input  logic mosi,
    output logic miso,
    output logic miso_oe
);

    logic [2:0]        pin_q;
    logic [2:0]        pin_p;
    logic              sel;
    logic              cs_rise;
    logic              sck_rise;
    logic              sck_fall;
    logic              busy;
    logic              wel;
    logic              dpd;
    logic [7:0]        status;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;
    logic              pb_clr;
    logic              pb_we;
    logic [PAGE_W-1:0] pb_idx;
    logic [7:0]        pb_data;
    logic              commit_vld;
    commit_t           commit;
    kind_e             commit_kind;
    logic              miso_bit;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_waddr;
    logic [7:0]        arr_wdata;
    logic [ADDR_W-1:0] arr_qaddr;
    logic [7:0]        arr_qdata;

    spi_flash_sync #(.W(3), .STAGES(SYNC_ST), .RST_VAL(3'b100)) sync_i (
        .clk(clk), .rst(rst), .d({csn, sclk, mosi}), .q(pin_q), .q_prev(pin_p)
    );

    assign sel         = ~pin_q[2];
    assign cs_rise     = pin_q[2] & ~pin_p[2];
    assign sck_rise    = pin_q[1] & ~pin_p[1];
    assign sck_fall    = ~pin_q[1] & pin_p[1];
    assign commit_kind = commit.kind;

    spi_flash_cmd #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) cmd_i (
        .clk(clk), .rst(rst), .sel(sel), .cs_rise(cs_rise),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(pin_q[0]),
        .busy(busy), .dpd(dpd), .status(status), .arr_rdata(rd_data),
        .arr_raddr(rd_addr), .pb_clr(pb_clr), .pb_we(pb_we), .pb_idx(pb_idx),
        .pb_data(pb_data), .commit_vld(commit_vld), .commit(commit),
        .miso_bit(miso_bit), .miso_oe(miso_oe)
    );

    spi_flash_exec #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECT_W(SECT_W),
        .T_PP(T_PP), .T_SE(T_SE), .T_BE(T_BE), .T_WRSR(T_WRSR)
    ) exec_i (
        .clk(clk), .rst(rst), .commit_vld(commit_vld), .commit(commit),
        .pb_clr(pb_clr), .pb_we(pb_we), .pb_idx(pb_idx), .pb_data(pb_data),
        .busy(busy), .wel(wel), .dpd(dpd), .status(status),
        .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
        .arr_qaddr(arr_qaddr), .arr_qdata(arr_qdata)
    );

    spi_flash_array #(.ADDR_W(ADDR_W)) array_i (
        .clk(clk), .rst(rst), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
        .raddr_a(rd_addr), .rdata_a(rd_data), .raddr_b(arr_qaddr), .rdata_b(arr_qdata)
    );

    assign miso = miso_oe ? miso_bit : 1'bz;

endmodule

// File: rtl/spi_flash_seq_chk.sv
module spi_flash_seq_chk
    import spi_flash_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  sel,
    input logic  miso_oe,
    input logic  busy,
    input logic  dpd,
    input logic  commit_vld,
    input kind_e commit_kind,
    input logic  pb_we,
    input logic  arr_we
);

    assert_oe_selected_R14: assert property (@(posedge clk) disable iff (rst)
        miso_oe |-> sel);

    assert_no_commit_busy_R10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !commit_vld);

    assert_no_pbuf_busy_R10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !pb_we);

    assert_arr_write_busy_R6: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy);

    assert_busy_from_commit_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(commit_vld));

    assert_sleep_release_only_R13: assert property (@(posedge clk) disable iff (rst)
        (dpd && commit_vld) |-> (commit_kind == K_RES));

endmodule

bind spi_flash_seq spi_flash_seq_chk chk_i (
    .clk(clk), .rst(rst), .sel(sel), .miso_oe(miso_oe), .busy(busy), .dpd(dpd),
    .commit_vld(commit_vld), .commit_kind(commit_kind), .pb_we(pb_we), .arr_we(arr_we)
);

// File: tb/spi_flash_seq_tb_top.sv
module spi_flash_seq_tb_top;

    localparam int H = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic csn = 1'b1;
    logic mosi = 1'b0;
    logic cpol = 1'b0;
    wire  miso;
    wire  miso_oe;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    logic [7:0] rx_b;
    logic       oe_seen;
    logic [7:0] wbuf [512];
    logic [7:0] rbuf [8];
    logic [7:0] shadow [1024];
    logic [7:0] st;

    localparam logic [17:0] VEC [6] = '{
        {10'h010, 8'hA5}, {10'h010, 8'h3C}, {10'h155, 8'h00},
        {10'h2FF, 8'h7E}, {10'h3FF, 8'hC3}, {10'h100, 8'h81}
    };

    always #4 clk = ~clk;

    spi_flash_seq dut_i (
        .clk(clk), .rst(rst), .sclk(sclk), .csn(csn), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe)
    );

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cs_low();
        sclk = cpol;
        oe_seen = 1'b0;
        csn = 1'b0;
        wclk(H);
    endtask

    task automatic cs_high();
        sclk = cpol;
        wclk(H);
        csn = 1'b1;
        wclk(4 * H);
    endtask

    task automatic xbits(input logic [7:0] o, input int n);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b0;
            mosi = o[7 - i];
            wclk(H);
            rx_b = {rx_b[6:0], miso};
            if (miso_oe === 1'b1) oe_seen = 1'b1;
            sclk = 1'b1;
            wclk(H);
        end
    endtask

    task automatic xb(input logic [7:0] o);
        xbits(o, 8);
    endtask

    task automatic cmd1(input logic [7:0] op);
        cs_low(); xb(op); cs_high();
    endtask

    task automatic rdsr();
        cs_low(); xb(8'h05); xb(8'h00); st = rx_b; cs_high();
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            rdsr();
            if (st[0] == 1'b0) break;
        end
    endtask

    task automatic rd(input logic [23:0] a, input int n, input bit fast);
        cs_low();
        xb(fast ? 8'h0B : 8'h03); xb(a[23:16]); xb(a[15:8]); xb(a[7:0]);
        if (fast) xb(8'h00);
        for (int i = 0; i < n; i++) begin xb(8'h00); rbuf[i] = rx_b; end
        cs_high();
    endtask

    task automatic pp(input logic [23:0] a, input int n, input bit apply);
        logic [7:0] pg [256];
        bit         pv [256];
        cs_low();
        xb(8'h02); xb(a[23:16]); xb(a[15:8]); xb(a[7:0]);
        for (int i = 0; i < n; i++) xb(wbuf[i]);
        cs_high();
        if (apply) begin
            for (int j = 0; j < 256; j++) pv[j] = 1'b0;
            for (int i = 0; i < n; i++) begin
                pg[(a[7:0] + i) % 256] = wbuf[i];
                pv[(a[7:0] + i) % 256] = 1'b1;
            end
            for (int j = 0; j < 256; j++)
                if (pv[j]) shadow[{a[9:8], 8'(j)}] = shadow[{a[9:8], 8'(j)}] & pg[j];
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) shadow[i] = 8'hFF;
        wclk(5);
        rst = 1'b0;
        wclk(2);

        // R1 / R14: reset state
        check("R14 oe after reset", {31'd0, miso_oe}, 32'd0);
        rdsr();
        check("R1 status after reset", {24'd0, st}, 32'h00);
        rd(24'h000123, 1, 1'b0);
        check("R1 array erased after reset", {24'd0, rbuf[0]}, 32'hFF);

        // R2: identification bytes; R14: no drive during opcode
        cs_low(); xb(8'h9F);
        check("R14 oe low during opcode", {31'd0, oe_seen}, 32'd0);
        for (int i = 0; i < 4; i++) begin xb(8'h00); rbuf[i] = rx_b; end
        cs_high();
        check("R2 id byte 0", {24'd0, rbuf[0]}, 32'h7F);
        check("R2 id byte 1", {24'd0, rbuf[1]}, 32'h37);
        check("R2 id byte 2", {24'd0, rbuf[2]}, 32'h02);
        check("R2 id byte 3", {24'd0, rbuf[3]}, 32'h13);

        // R3: write enable and disable
        cmd1(8'h06); rdsr();
        check("R3 wel set", {24'd0, st}, 32'h02);
        cmd1(8'h04); rdsr();
        check("R3 wel cleared", {24'd0, st}, 32'h00);

        // R4: program without enable has no effect
        wbuf[0] = 8'h00;
        pp(24'h000020, 1, 1'b0);
        rdsr();
        check("R4 no busy without wel", {24'd0, st}, 32'h00);
        rd(24'h000020, 1, 1'b0);
        check("R4 array untouched", {24'd0, rbuf[0]}, 32'hFF);

        // R5: byte boundary rule
        cs_low(); xb(8'h06); xbits(8'h80, 1); cs_high();
        rdsr();
        check("R5 wren with 9 bits discarded", {24'd0, st}, 32'h00);
        cmd1(8'h06);
        cs_low(); xb(8'h02); xb(8'h00); xb(8'h00); xb(8'h40); xb(8'h00); xbits(8'h00, 3); cs_high();
        rdsr();
        check("R5 partial program discarded", {24'd0, st}, 32'h02);
        rd(24'h000040, 1, 1'b0);
        check("R5 array untouched", {24'd0, rbuf[0]}, 32'hFF);
        cmd1(8'h04);

        // R6: table of program / readback vectors
        for (int v = 0; v < 6; v++) begin
            cmd1(8'h06);
            wbuf[0] = VEC[v][7:0];
            pp({14'd0, VEC[v][17:8]}, 1, 1'b1);
            if (v == 0) begin
                rdsr();
                check("R6 busy and wel cleared", {30'd0, st[1:0]}, 32'h1);
            end
            wait_idle();
            rd({14'd0, VEC[v][17:8]}, 1, 1'b0);
            check("R6 program and-result", {24'd0, rbuf[0]}, {24'd0, shadow[VEC[v][17:8]]});
        end
        rdsr();
        check("R6 idle after program", {24'd0, st}, 32'h00);

        // R7: wrap within page
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        cmd1(8'h06); pp(24'h0000FE, 4, 1'b1); wait_idle();
        rd(24'h0000FE, 2, 1'b0);
        check("R7 byte at FE", {24'd0, rbuf[0]}, 32'h11);
        check("R7 byte at FF", {24'd0, rbuf[1]}, 32'h22);
        rd(24'h000000, 2, 1'b0);
        check("R7 wrapped to 00", {24'd0, rbuf[0]}, 32'h33);
        check("R7 wrapped to 01", {24'd0, rbuf[1]}, 32'h44);

        // R8: more than a page keeps the last 256
        for (int i = 0; i < 258; i++) wbuf[i] = 8'(i * 7 + 3);
        cmd1(8'h06); pp(24'h000200, 258, 1'b1); wait_idle();
        rd(24'h000200, 3, 1'b0);
        check("R8 slot0 from byte 256", {24'd0, rbuf[0]}, {24'd0, 8'(256 * 7 + 3)});
        check("R8 slot1 from byte 257", {24'd0, rbuf[1]}, {24'd0, 8'(257 * 7 + 3)});
        check("R8 slot2 from byte 2", {24'd0, rbuf[2]}, {24'd0, 8'(2 * 7 + 3)});

        // R9: read wrap at top, upper address ignored, fast read
        rd(24'hF003FF, 3, 1'b0);
        check("R9 top byte", {24'd0, rbuf[0]}, {24'd0, shadow[10'h3FF]});
        check("R9 wrap to zero", {24'd0, rbuf[1]}, {24'd0, shadow[10'h000]});
        check("R9 increment", {24'd0, rbuf[2]}, {24'd0, shadow[10'h001]});
        rd(24'h0000FE, 2, 1'b1);
        check("R9 fast read first", {24'd0, rbuf[0]}, 32'h11);
        check("R9 fast read second", {24'd0, rbuf[1]}, 32'h22);

        // R10 / R11: sector erase while probing the busy window
        cmd1(8'h06);
        cs_low(); xb(8'hD8); xb(8'h00); xb(8'h02); xb(8'h10); cs_high();
        cmd1(8'h06);
        rdsr();
        check("R10 busy, wren ignored", {30'd0, st[1:0]}, 32'h1);
        rd(24'h000010, 1, 1'b0);
        check("R10 read rejected while busy", {31'd0, oe_seen}, 32'd0);
        wait_idle();
        rdsr();
        check("R10 wel still clear", {24'd0, st}, 32'h00);
        for (int i = 512; i < 1024; i++) shadow[i] = 8'hFF;
        rd(24'h000200, 1, 1'b0);
        check("R11 sector start erased", {24'd0, rbuf[0]}, 32'hFF);
        rd(24'h0003FF, 1, 1'b0);
        check("R11 sector end erased", {24'd0, rbuf[0]}, 32'hFF);
        rd(24'h000010, 1, 1'b0);
        check("R11 other sector kept", {24'd0, rbuf[0]}, {24'd0, shadow[10'h010]});

        // R12: status write
        cmd1(8'h06);
        cs_low(); xb(8'h01); xb(8'hFF); cs_high();
        wait_idle(); rdsr();
        check("R12 stored status bits", {24'd0, st}, 32'h9C);
        cs_low(); xb(8'h01); xb(8'h00); cs_high();
        wait_idle(); rdsr();
        check("R4 status write needs wel", {24'd0, st}, 32'h9C);
        cmd1(8'h06);
        cs_low(); xb(8'h01); xb(8'h00); cs_high();
        wait_idle(); rdsr();
        check("R12 status cleared", {24'd0, st}, 32'h00);

        // R11: bulk erase
        cmd1(8'h06); cmd1(8'hC7); wait_idle();
        rd(24'h000010, 1, 1'b0);
        check("R11 bulk erase low", {24'd0, rbuf[0]}, 32'hFF);
        rd(24'h0000FE, 1, 1'b0);
        check("R11 bulk erase page end", {24'd0, rbuf[0]}, 32'hFF);

        // R13: deep power-down
        cmd1(8'hB9);
        cs_low(); xb(8'h05); xb(8'h00); cs_high();
        check("R13 status read ignored", {31'd0, oe_seen}, 32'd0);
        cmd1(8'h06);
        cs_low(); xb(8'hAB); xb(8'h00); xb(8'h00); xb(8'h00);
        xb(8'h00); rbuf[0] = rx_b; xb(8'h00); rbuf[1] = rx_b;
        cs_high();
        check("R13 signature", {24'd0, rbuf[0]}, 32'h13);
        check("R13 signature repeats", {24'd0, rbuf[1]}, 32'h13);
        rdsr();
        check("R13 released, wren was ignored", {24'd0, st}, 32'h00);

        // R2: clock idling high
        cpol = 1'b1;
        sclk = 1'b1;
        wclk(4 * H);
        cs_low(); xb(8'h9F); xb(8'h00); rbuf[0] = rx_b; xb(8'h00); rbuf[1] = rx_b; cs_high();
        check("R2 idle-high id byte 0", {24'd0, rbuf[0]}, 32'h7F);
        check("R2 idle-high id byte 1", {24'd0, rbuf[1]}, 32'h37);
        check("R14 oe low when deselected", {31'd0, miso_oe}, 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule